// File: doc/BRIEF.md
# Hardware Process Dispatch Scheduler

This block chooses which process a microcoded processor runs next, and it does so in hardware. Each process slot has a single active bit. A lowest-index-first priority encoder selects one active slot. The encoder's output indexes a small register file that holds a resume address for every slot. The selected entry is presented to the microsequencer as its next fetch address. A change of context therefore costs no microcode cycles: a suspend, a wake-up and the new fetch address all take effect at the same clock edge.

Slots fall into three classes. Real-time slots wake on their own hardware interrupt line. Memory-return slots wake when data for an earlier memory request comes back. Default slots hold non-urgent work and can only be started by a command from a running real-time process. A process that issues a memory request gives a continuation address and a memory-return slot tag. The address is stored in that slot's entry, and the tag goes into an in-order queue. Each memory return takes the oldest tag off the queue and wakes the matching slot. A process can also yield with a resume address of its own.

Top module: `pds_dispatch`

## Requirements
- R1: A synchronous reset clears every active bit and empties the tag queue. While no slot is active, `disp_valid_o` is 0 and both `disp_slot_o` and `disp_addr_o` read 0. `mreq_ready_o` is 1 after reset.
- R2: Slots 0–3 are real-time, slots 4–11 are memory-return and slots 12–15 are default. The active slot with the lowest number is dispatched.
- R3: `irq_i[k]` high at a rising edge sets the active bit of slot k.
- R4: `disp_addr_o` is the register-file entry of the dispatched slot. `init_we_i` writes `init_addr_i` into entry `init_slot_i`.
- R5: A memory request is accepted when `mreq_valid_i` is high, a slot is dispatched and `mreq_ready_o` is high. On acceptance the dispatched slot's bit clears, `mreq_cont_i` is written to entry 4+`mreq_tag_i`, and the tag is queued. A request that is not accepted changes nothing.
- R6: `mret_valid_i` removes the oldest queued tag t and sets slot 4+t, so slots wake in request order. With an empty queue the return is ignored.
- R7: When `yield_valid_i` is high, `mreq_valid_i` is low and a slot is dispatched, that slot's bit clears and `yield_cont_i` is written to its entry.
- R8: `dflt_start_i` sets slot 12+`dflt_idx_i` only when the dispatched slot is real-time (0–3). In any other case it is ignored.
- R9: When the same slot is set and cleared at one edge, it stays active.
- R10: When a suspend write and `init_we_i` target the same entry at one edge, the suspend address is stored.
- R11: `mreq_ready_o` is 0 exactly when QDEPTH (4) tags are outstanding. It stays 0 until a return arrives.
- R12: Every input takes effect at the next rising edge. A cycle with no stimulus leaves the dispatched slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| irq_i | input | 4 | One interrupt line per real-time slot |
| mreq_valid_i | input | 1 | Running process issues a memory request |
| mreq_tag_i | input | 3 | Memory-return slot to wake on completion |
| mreq_cont_i | input | 12 | Continuation address for that slot |
| mreq_ready_o | output | 1 | Tag queue can take a request |
| mret_valid_i | input | 1 | Memory data returned for the oldest request |
| yield_valid_i | input | 1 | Running process suspends itself |
| yield_cont_i | input | 12 | Resume address for the yielding slot |
| dflt_start_i | input | 1 | Start a default process |
| dflt_idx_i | input | 2 | Default slot to start |
| init_we_i | input | 1 | Write a slot's start address |
| init_slot_i | input | 4 | Entry to write |
| init_addr_i | input | 12 | Start address |
| disp_valid_o | output | 1 | A slot is dispatched |
| disp_slot_o | output | 4 | Dispatched slot |
| disp_addr_o | output | 12 | Next microcode fetch address |

## Verification
Every result is due exactly one rising edge after its stimulus. The active bits, the register file and the queue are all single-register stages, and the outputs decode them combinationally. The bench drives each stimulus on a falling edge and samples a few nanoseconds after the following rising edge. Its behavioural model moves forward one edge at the same moment. Stimulus is then dropped on the next falling edge, so no input lasts past the edge it was meant for. The directed sequences cover the cases where the sampled cycle matters: a refused request with a full queue, a return on an empty queue, a set and a clear of the same slot, and an init write that coincides with a suspend. A pseudo-random run then compares every output after every edge.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;

   typedef enum logic [1:0] {
      CLS_RT = 2'd0,
      CLS_MR = 2'd1,
      CLS_DF = 2'd2
   } slot_class_e;

   // Class of a slot number given the real-time and memory-return counts.
   function automatic slot_class_e class_of(input int unsigned slot,
                                            input int unsigned n_rt,
                                            input int unsigned n_mr);
      if (slot < n_rt)        return CLS_RT;
      if (slot < n_rt + n_mr) return CLS_MR;
      return CLS_DF;
   endfunction

endpackage

// File: rtl/pds_prio_enc.sv
`timescale 1ns/1ps
module pds_prio_enc #(
   parameter int N  = 16,
   parameter int SW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          valid_o,
   output logic [SW-1:0] idx_o
);
   if (N < 2) begin : g_bad_n
      $error("pds_prio_enc: N must be at least 2");
   end

   // Lowest index wins.
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = SW'(i);
      end
   end

   assign valid_o = |req_i;
endmodule

// File: rtl/pds_addr_ram.sv
`timescale 1ns/1ps
module pds_addr_ram #(
   parameter int N  = 16,
   parameter int AW = 12,
   parameter int SW = $clog2(N)
) (
   input  logic          clk_i,
   // three write ports, highest precedence first
   input  logic          hi_we_i,
   input  logic [SW-1:0] hi_idx_i,
   input  logic [AW-1:0] hi_data_i,
   input  logic          mid_we_i,
   input  logic [SW-1:0] mid_idx_i,
   input  logic [AW-1:0] mid_data_i,
   input  logic          lo_we_i,
   input  logic [SW-1:0] lo_idx_i,
   input  logic [AW-1:0] lo_data_i,
   input  logic [SW-1:0] rd_idx_i,
   output logic [AW-1:0] rd_data_o
);
   if (AW < 1) begin : g_bad_aw
      $error("pds_addr_ram: AW must be positive");
   end

   logic [AW-1:0] mem [N];

   // Edge-updated entries; the read is combinational, so a write lands
   // before the entry is read in the following cycle.
   always_ff @(posedge clk_i) begin
      for (int e = 0; e < N; e++) begin
         if (hi_we_i && hi_idx_i == SW'(e))        mem[e] <= hi_data_i;
         else if (mid_we_i && mid_idx_i == SW'(e)) mem[e] <= mid_data_i;
         else if (lo_we_i && lo_idx_i == SW'(e))   mem[e] <= lo_data_i;
      end
   end

   assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/pds_tag_fifo.sv
`timescale 1ns/1ps
module pds_tag_fifo #(
   parameter int DEPTH = 4,
   parameter int TW    = 3
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          push_i,
   input  logic [TW-1:0] push_tag_i,
   input  logic          pop_i,
   output logic [TW-1:0] head_o,
   output logic          empty_o,
   output logic          full_o
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("pds_tag_fifo: DEPTH must be at least 2");
   end

   logic [TW-1:0] store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty_o = count == '0;
   assign full_o  = count == CW'(DEPTH);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign head_o  = store[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk_i) begin
      if (do_push) store[wr_ptr] <= push_tag_i;
   end
endmodule

// File: rtl/pds_dispatch.sv
`timescale 1ns/1ps
module pds_dispatch
   import pds_pkg::*;
#(
   parameter  int N_RT   = 4,
   parameter  int N_MR   = 8,
   parameter  int N_DF   = 4,
   parameter  int AW     = 12,
   parameter  int QDEPTH = 4,
   localparam int NSLOT  = N_RT + N_MR + N_DF,
   localparam int SW     = $clog2(NSLOT),
   localparam int TW     = $clog2(N_MR),
   localparam int DW     = $clog2(N_DF)
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [N_RT-1:0] irq_i,
   input  logic            mreq_valid_i,
   input  logic [TW-1:0]   mreq_tag_i,
   input  logic [AW-1:0]   mreq_cont_i,
   output logic            mreq_ready_o,
   input  logic            mret_valid_i,
   input  logic            yield_valid_i,
   input  logic [AW-1:0]   yield_cont_i,
   input  logic            dflt_start_i,
   input  logic [DW-1:0]   dflt_idx_i,
   input  logic            init_we_i,
   input  logic [SW-1:0]   init_slot_i,
   input  logic [AW-1:0]   init_addr_i,
   output logic            disp_valid_o,
   output logic [SW-1:0]   disp_slot_o,
   output logic [AW-1:0]   disp_addr_o
);
   if (N_RT < 1) begin : g_bad_rt
      $error("pds_dispatch: N_RT must be at least 1");
   end
   if (N_MR < 2 || N_DF < 2) begin : g_bad_cls
      $error("pds_dispatch: N_MR and N_DF must be at least 2");
   end

   logic [NSLOT-1:0] active_q, active_d, set_vec, clr_vec;
   logic             enc_valid;
   logic [SW-1:0]    cur_slot;
   logic [AW-1:0]    rd_addr;
   logic             fifo_full, fifo_empty;
   logic [TW-1:0]    fifo_head;
   logic             mreq_acc, yield_acc, ret_fire, df_fire, cur_is_rt;
   logic [SW-1:0]    mreq_entry;

   pds_prio_enc #(.N(NSLOT), .SW(SW)) u_enc (
      .req_i   (active_q),
      .valid_o (enc_valid),
      .idx_o   (cur_slot)
   );

   assign cur_is_rt  = class_of({{(32 - SW){1'b0}}, cur_slot}, N_RT, N_MR) == CLS_RT;
   assign mreq_acc   = mreq_valid_i && !fifo_full && enc_valid;
   assign yield_acc  = yield_valid_i && !mreq_valid_i && enc_valid;
   assign ret_fire   = mret_valid_i && !fifo_empty;
   assign df_fire    = dflt_start_i && enc_valid && cur_is_rt;
   assign mreq_entry = SW'(N_RT) + SW'(mreq_tag_i);

   pds_tag_fifo #(.DEPTH(QDEPTH), .TW(TW)) u_tags (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .push_i     (mreq_acc),
      .push_tag_i (mreq_tag_i),
      .pop_i      (ret_fire),
      .head_o     (fifo_head),
      .empty_o    (fifo_empty),
      .full_o     (fifo_full)
   );

   pds_addr_ram #(.N(NSLOT), .AW(AW), .SW(SW)) u_ram (
      .clk_i      (clk_i),
      .hi_we_i    (mreq_acc),
      .hi_idx_i   (mreq_entry),
      .hi_data_i  (mreq_cont_i),
      .mid_we_i   (yield_acc),
      .mid_idx_i  (cur_slot),
      .mid_data_i (yield_cont_i),
      .lo_we_i    (init_we_i),
      .lo_idx_i   (init_slot_i),
      .lo_data_i  (init_addr_i),
      .rd_idx_i   (cur_slot),
      .rd_data_o  (rd_addr)
   );

   // Wake-up sources, one group per class.
   for (genvar r = 0; r < N_RT; r++) begin : g_rt_set
      assign set_vec[r] = irq_i[r];
   end
   for (genvar m = 0; m < N_MR; m++) begin : g_mr_set
      assign set_vec[N_RT + m] = ret_fire && fifo_head == TW'(m);
   end
   for (genvar d = 0; d < N_DF; d++) begin : g_df_set
      assign set_vec[N_RT + N_MR + d] = df_fire && dflt_idx_i == DW'(d);
   end

   assign clr_vec  = (mreq_acc || yield_acc) ? (NSLOT'(1) << cur_slot) : '0;
   // A wake-up overrides a suspend of the same slot.
   assign active_d = (active_q & ~clr_vec) | set_vec;

   always_ff @(posedge clk_i) begin
      if (rst_i) active_q <= '0;
      else       active_q <= active_d;
   end

   assign mreq_ready_o = !fifo_full;
   assign disp_valid_o = enc_valid;
   assign disp_slot_o  = cur_slot;
   assign disp_addr_o  = enc_valid ? rd_addr : '0;
endmodule

// File: rtl/pds_checker.sv
`timescale 1ns/1ps
module pds_checker #(
   parameter int N_RT = 4,
   parameter int SW   = 4,
   parameter int AW   = 12
) (
   input logic            clk_i,
   input logic            rst_i,
   input logic [N_RT-1:0] irq_i,
   input logic            mreq_valid_i,
   input logic            mret_valid_i,
   input logic            yield_valid_i,
   input logic            dflt_start_i,
   input logic            init_we_i,
   input logic [SW-1:0]   init_slot_i,
   input logic [AW-1:0]   init_addr_i,
   input logic            mreq_ready_o,
   input logic            disp_valid_o,
   input logic [SW-1:0]   disp_slot_o,
   input logic [AW-1:0]   disp_addr_o
);
   logic no_wake;
   assign no_wake = irq_i == '0 && !mret_valid_i && !dflt_start_i;

   assert_irq_wakes_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_i != '0 |=> disp_valid_o);

   assert_slot0_first_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_i[0] |=> disp_valid_o && disp_slot_o == '0);

   assert_init_seen_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      init_we_i && no_wake && !mreq_valid_i && !yield_valid_i && disp_valid_o
      && init_slot_i == disp_slot_o |=> disp_addr_o == $past(init_addr_i));

   assert_full_holds_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      !mreq_ready_o && !mret_valid_i |=> !mreq_ready_o);

   assert_idle_stable_R12: assert property (@(posedge clk_i) disable iff (rst_i)
      no_wake && !mreq_valid_i && !yield_valid_i
      |=> $stable(disp_valid_o) && $stable(disp_slot_o));

   assert_dflt_needs_rt_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      dflt_start_i && !disp_valid_o && irq_i == '0 && !mret_valid_i |=> !disp_valid_o);
endmodule

bind pds_dispatch pds_checker #(.N_RT(N_RT), .SW(SW), .AW(AW)) u_chk (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .irq_i         (irq_i),
   .mreq_valid_i  (mreq_valid_i),
   .mret_valid_i  (mret_valid_i),
   .yield_valid_i (yield_valid_i),
   .dflt_start_i  (dflt_start_i),
   .init_we_i     (init_we_i),
   .init_slot_i   (init_slot_i),
   .init_addr_i   (init_addr_i),
   .mreq_ready_o  (mreq_ready_o),
   .disp_valid_o  (disp_valid_o),
   .disp_slot_o   (disp_slot_o),
   .disp_addr_o   (disp_addr_o)
);

// File: tb/pds_dispatch_tb.sv
`timescale 1ns/1ps
module pds_dispatch_tb;
   localparam int NS = 16;
   localparam int QD = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst;
   logic [3:0]  irq;
   logic        mreq_valid, mret_valid, yield_valid, dflt_start, init_we;
   logic [2:0]  mreq_tag;
   logic [11:0] mreq_cont, yield_cont, init_addr;
   logic [1:0]  dflt_idx;
   logic [3:0]  init_slot;
   logic        mreq_ready, disp_valid;
   logic [3:0]  disp_slot;
   logic [11:0] disp_addr;

   pds_dispatch u_dut (
      .clk_i(clk), .rst_i(rst), .irq_i(irq),
      .mreq_valid_i(mreq_valid), .mreq_tag_i(mreq_tag), .mreq_cont_i(mreq_cont),
      .mreq_ready_o(mreq_ready), .mret_valid_i(mret_valid),
      .yield_valid_i(yield_valid), .yield_cont_i(yield_cont),
      .dflt_start_i(dflt_start), .dflt_idx_i(dflt_idx),
      .init_we_i(init_we), .init_slot_i(init_slot), .init_addr_i(init_addr),
      .disp_valid_o(disp_valid), .disp_slot_o(disp_slot), .disp_addr_o(disp_addr)
   );

   int total = 0;
   int bad   = 0;

   // stimulus for the next step
   logic [3:0]  s_irq;
   logic        s_mv, s_rv, s_yv, s_dv, s_iw;
   logic [2:0]  s_mt;
   logic [11:0] s_ma, s_ya, s_ia;
   logic [1:0]  s_di;
   logic [3:0]  s_is;

   // behavioural model built from the requirements
   logic [NS-1:0] m_flag;
   logic [11:0]   m_ram [NS];
   logic [2:0]    m_q [QD];
   int            m_cnt;

   function automatic logic [11:0] fa(input int s);
      return 12'((s * 293 + 11) % 4096);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic stim_clear();
      s_irq = '0; s_mv = 0; s_rv = 0; s_yv = 0; s_dv = 0; s_iw = 0;
      s_mt = '0; s_ma = '0; s_ya = '0; s_ia = '0; s_di = '0; s_is = '0;
   endtask

   task automatic drive_idle();
      irq = '0; mreq_valid = 0; mret_valid = 0; yield_valid = 0; dflt_start = 0;
      init_we = 0; mreq_tag = '0; mreq_cont = '0; yield_cont = '0; dflt_idx = '0;
      init_slot = '0; init_addr = '0;
   endtask

   function automatic int lowest(input logic [NS-1:0] f);
      int c;
      c = -1;
      for (int i = NS - 1; i >= 0; i--) if (f[i]) c = i;
      return c;
   endfunction

   task automatic model_edge();
      int cur;
      logic macc, yacc;
      logic [NS-1:0] setv, clrv;
      cur  = lowest(m_flag);
      macc = s_mv && cur >= 0 && m_cnt < QD;
      yacc = s_yv && !s_mv && cur >= 0;
      setv = '0;
      clrv = '0;
      if (macc || yacc) clrv[cur] = 1'b1;
      setv[3:0] = s_irq;
      if (s_rv && m_cnt > 0) begin
         setv[4 + int'(m_q[0])] = 1'b1;
         for (int j = 0; j < QD - 1; j++) m_q[j] = m_q[j + 1];
         m_cnt--;
      end
      if (macc) begin
         m_q[m_cnt] = s_mt;
         m_cnt++;
      end
      if (s_dv && cur >= 0 && cur < 4) setv[12 + int'(s_di)] = 1'b1;
      if (s_iw) m_ram[s_is] = s_ia;
      if (yacc) m_ram[cur] = s_ya;
      if (macc) m_ram[4 + int'(s_mt)] = s_ma;
      m_flag = (m_flag & ~clrv) | setv;
   endtask

   // One stimulus edge: drive on the falling edge, sample after the next
   // rising edge, drop the stimulus on the falling edge after that.
   task automatic step(input string req);
      int c;
      @(negedge clk);
      irq = s_irq; mreq_valid = s_mv; mreq_tag = s_mt; mreq_cont = s_ma;
      mret_valid = s_rv; yield_valid = s_yv; yield_cont = s_ya;
      dflt_start = s_dv; dflt_idx = s_di; init_we = s_iw; init_slot = s_is;
      init_addr = s_ia;
      model_edge();
      @(posedge clk);
      #3;
      c = lowest(m_flag);
      chk(req, "disp_valid", int'(disp_valid), (c >= 0) ? 1 : 0);
      chk(req, "disp_slot",  int'(disp_slot),  (c >= 0) ? c : 0);
      chk(req, "disp_addr",  int'(disp_addr),  (c >= 0) ? int'(m_ram[c]) : 0);
      chk(req, "mreq_ready", int'(mreq_ready), (m_cnt < QD) ? 1 : 0);
      @(negedge clk);
      drive_idle();
      stim_clear();
   endtask

   task automatic irq_step(input logic [3:0] v, input string req);
      s_irq = v; step(req);
   endtask
   task automatic yield_step(input logic [11:0] a, input string req);
      s_yv = 1; s_ya = a; step(req);
   endtask
   task automatic mreq_step(input logic [2:0] t, input logic [11:0] a, input string req);
      s_mv = 1; s_mt = t; s_ma = a; step(req);
   endtask
   task automatic mret_step(input string req);
      s_rv = 1; step(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned lf;
      drive_idle();
      stim_clear();
      m_flag = '0;
      m_cnt  = 0;
      for (int i = 0; i < NS; i++) m_ram[i] = '0;
      for (int i = 0; i < QD; i++) m_q[i] = '0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state
      chk("R1", "disp_valid", int'(disp_valid), 0);
      chk("R1", "disp_slot",  int'(disp_slot),  0);
      chk("R1", "disp_addr",  int'(disp_addr),  0);
      chk("R1", "mreq_ready", int'(mreq_ready), 1);

      // R4: initialise every entry
      for (int s = 0; s < NS; s++) begin
         s_iw = 1; s_is = 4'(s); s_ia = fa(s); step("R4");
      end

      // R3: each interrupt line wakes its own slot; R7 yield clears it
      for (int k = 0; k < 4; k++) begin
         irq_step(4'(1 << k), "R3");
         chk("R3", "slot", int'(disp_slot), k);
         chk("R4", "addr", int'(disp_addr), int'(fa(k)));
         yield_step(12'h800 + 12'(k), "R7");
         chk("R7", "valid", int'(disp_valid), 0);
      end

      // R2: all four at once, served in index order
      irq_step(4'hF, "R2");
      chk("R2", "slot", int'(disp_slot), 0);
      for (int k = 0; k < 4; k++) begin
         yield_step(12'h900 + 12'(k), "R2");
         if (k < 3) chk("R2", "slot", int'(disp_slot), k + 1);
         else       chk("R2", "valid", int'(disp_valid), 0);
      end

      // R5/R11/R6: memory requests, full queue, in-order returns
      irq_step(4'b0100, "R5"); mreq_step(3'd5, 12'h3A1, "R5");
      chk("R5", "valid", int'(disp_valid), 0);
      irq_step(4'b0010, "R5"); mreq_step(3'd2, 12'h155, "R5");
      irq_step(4'b1000, "R5"); mreq_step(3'd7, 12'h2C2, "R5");
      irq_step(4'b0001, "R5"); mreq_step(3'd0, 12'h0AB, "R11");
      chk("R11", "ready", int'(mreq_ready), 0);
      irq_step(4'b0010, "R5"); mreq_step(3'd3, 12'h777, "R5");
      chk("R5", "refused keeps slot", int'(disp_slot), 1);
      yield_step(12'h901, "R7");
      mret_step("R6");
      chk("R6", "slot", int'(disp_slot), 9);
      chk("R6", "addr", int'(disp_addr), 'h3A1);
      chk("R11", "ready", int'(mreq_ready), 1);
      mret_step("R6");
      chk("R6", "slot", int'(disp_slot), 6);
      mret_step("R6");
      mret_step("R6");
      chk("R6", "slot", int'(disp_slot), 4);
      chk("R6", "addr", int'(disp_addr), 'h0AB);
      yield_step(12'h040, "R7"); chk("R6", "slot", int'(disp_slot), 6);
      yield_step(12'h060, "R7"); chk("R6", "slot", int'(disp_slot), 9);
      yield_step(12'h090, "R7"); chk("R6", "slot", int'(disp_slot), 11);
      yield_step(12'h0B0, "R7");
      mret_step("R6");
      chk("R6", "empty return ignored", int'(disp_valid), 0);

      // R8: default start only from a real-time slot
      s_dv = 1; s_di = 2'd2; step("R8");
      chk("R8", "idle ignored", int'(disp_valid), 0);
      irq_step(4'b0001, "R8"); mreq_step(3'd1, 12'h111, "R8");
      mret_step("R8");
      chk("R8", "slot", int'(disp_slot), 5);
      s_dv = 1; s_di = 2'd2; step("R8");
      yield_step(12'h222, "R8");
      chk("R8", "from memory slot ignored", int'(disp_valid), 0);
      irq_step(4'b1000, "R8");
      s_dv = 1; s_di = 2'd2; step("R8");
      chk("R8", "slot", int'(disp_slot), 3);
      yield_step(12'h333, "R8");
      chk("R8", "slot", int'(disp_slot), 14);
      chk("R8", "addr", int'(disp_addr), int'(fa(14)));
      yield_step(12'h444, "R8");

      // R9: wake and suspend of one slot together
      irq_step(4'b0100, "R9");
      s_irq = 4'b0100; s_yv = 1; s_ya = 12'h777; step("R9");
      chk("R9", "valid", int'(disp_valid), 1);
      chk("R9", "slot", int'(disp_slot), 2);
      chk("R9", "addr", int'(disp_addr), 'h777);
      yield_step(12'h100, "R9");

      // R10: suspend write beats init write
      irq_step(4'b0010, "R10");
      s_yv = 1; s_ya = 12'h5A5; s_iw = 1; s_is = 4'd1; s_ia = 12'h0F0; step("R10");
      irq_step(4'b0010, "R10");
      chk("R10", "addr", int'(disp_addr), 'h5A5);
      yield_step(12'h5A5, "R10");

      // R4: init while running is seen next cycle
      irq_step(4'b0001, "R4");
      s_iw = 1; s_is = 4'd0; s_ia = 12'hABC; step("R4");
      chk("R4", "addr", int'(disp_addr), 'hABC);
      yield_step(12'h010, "R4");

      // R12: pseudo-random run against the model
      lf = 32'h1234_5678;
      for (int n = 0; n < 1500; n++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         s_irq = (lf[5:4] == 2'b00) ? lf[3:0] : 4'b0;
         s_mv  = lf[6] & lf[7];
         s_mt  = lf[10:8];
         s_ma  = lf[22:11];
         s_rv  = lf[23] & lf[24];
         s_yv  = lf[25];
         s_ya  = lf[31:20];
         s_dv  = lf[26] & lf[27];
         s_di  = lf[29:28];
         s_iw  = lf[30] & lf[31] & lf[12];
         s_is  = lf[19:16];
         s_ia  = lf[15:4];
         step("R12");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule